// File: doc/BRIEF.md
# Mirror Clocking Pulse Output Selector

This block models the digital control side of a mirror clocking-pulse driver that has sixteen output channels. Each channel carries a two-bit level code, which names bias, offset or reset, and a high-impedance flag. A command is made of a group-size mode, a level select and a channel address. It is sampled on the rising edge of a strobe. The channels the command selects float at once. After a break-before-make delay of a set number of clock cycles, they take the new level. Every channel the command does not select keeps its present level.

The strobe is an ordinary data input sampled by the block clock, and only its low-to-high transition issues a command. While a delay window is open, the block ignores any further strobe edge. A level select of 3 is not allowed: it changes no channel and raises an error flag.

Top module: `mcp_out_sel`

## Requirements
- R1: After reset every channel level code is 01 (offset), no channel is high-impedance, `busy` is low and `sel_err` is low.
- R2: The mode field `grp_mode` selects the channel group. 00 selects the one channel `grp_addr`. 01 selects the pair that starts at `grp_addr` with bit 0 cleared. 10 selects the four channels that start at `grp_addr` with bits 1:0 cleared. 11 selects all channels.
- R3: A strobe rise sampled at a clock edge while the block is idle, with a legal select, sets `ch_hiz` for exactly the selected channels after that same edge.
- R4: The selected channels stay high-impedance for exactly `BBM_CYC` cycles. Their level codes stay unchanged for that whole time. At the end of the window `ch_hiz` clears and each selected channel takes the sampled `lvl_sel` code: 00 bias, 01 offset, 10 reset. Channel i occupies `ch_level[2i+1:2i]`.
- R5: The level code and high-impedance flag of an unselected channel are not changed by a command.
- R6: A strobe rise that arrives while a delay window is open is ignored. It does not change the selection, the pending level or `sel_err`.
- R7: A strobe rise at idle with `lvl_sel` = 11 leaves every channel unchanged and does not open a window. It sets `sel_err` after that edge. The flag stays set until the next accepted legal command, which clears it.
- R8: `busy` is high for exactly the cycles in which the delay window is open.
- R9: A strobe held high issues only one command. A new command needs the strobe to go low and then high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| strobe | input | 1 | Command strobe; its rising edge issues a command |
| grp_mode | input | 2 | Group size: single, pair, quad, all |
| lvl_sel | input | 2 | Level to latch: 00 bias, 01 offset, 10 reset |
| grp_addr | input | AW | Channel address, aligned down to the group size |
| ch_level | output | 2*NCH | Latched level code per channel |
| ch_hiz | output | NCH | High-impedance flag per channel |
| busy | output | 1 | Break-before-make window open |
| sel_err | output | 1 | Last command at idle carried an illegal select |

## Verification
A command that issues at edge T shows its float mask, `busy` and the cleared `sel_err` right after edge T. The float holds through edge T+BBM_CYC-1, and the new levels appear, with the float gone, right after edge T+BBM_CYC. An illegal select shows `sel_err` after edge T and leaves `busy` low. The bench drives inputs and samples outputs on falling edges. It checks the float mask once per cycle through the window and compares the full level vector to its model after the release edge. A strobe injected so that it rises at edge T+2 must change neither the mask nor the final levels.

// File: rtl/mcp_out_sel.sv
module mcp_out_sel #(
  parameter int NCH     = 16,
  parameter int BBM_CYC = 4,
  localparam int AW     = $clog2(NCH),
  localparam int CW     = $clog2(BBM_CYC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  logic [1:0]       grp_mode,
  input  logic [1:0]       lvl_sel,
  input  logic [AW-1:0]    grp_addr,
  output logic [2*NCH-1:0] ch_level,
  output logic [NCH-1:0]   ch_hiz,
  output logic             busy,
  output logic             sel_err
);

  localparam logic [1:0] LVL_OFFSET = 2'b01;
  localparam logic [1:0] LVL_BAD    = 2'b11;

  logic           strobe_q;
  logic [CW-1:0]  cnt;
  logic [NCH-1:0] pend;
  logic [1:0]     pend_lvl;
  logic [NCH-1:0] grp_hit;

  wire rise        = strobe & ~strobe_q;
  wire accept      = rise && (cnt == '0);
  wire legal       = (lvl_sel != LVL_BAD);
  wire release_now = (cnt == CW'(1));

  assign busy = (cnt != '0);

  for (genvar i = 0; i < NCH; i++) begin : g_hit
    assign grp_hit[i] = (grp_mode == 2'b11) ||
                        ((AW'(i) >> grp_mode) == (grp_addr >> grp_mode));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      cnt      <= '0;
      pend     <= '0;
      pend_lvl <= LVL_OFFSET;
      ch_hiz   <= '0;
      sel_err  <= 1'b0;
    end else begin
      strobe_q <= strobe;
      if (accept) begin
        if (legal) begin
          cnt      <= CW'(BBM_CYC);
          pend     <= grp_hit;
          pend_lvl <= lvl_sel;
          ch_hiz   <= grp_hit;
          sel_err  <= 1'b0;
        end else begin
          sel_err  <= 1'b1;
        end
      end else if (busy) begin
        cnt <= cnt - CW'(1);
        if (release_now) ch_hiz <= '0;
      end
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_lvl
    always_ff @(posedge clk) begin
      if (!rst_n)
        ch_level[2*i +: 2] <= LVL_OFFSET;
      else if (!accept && release_now && pend[i])
        ch_level[2*i +: 2] <= pend_lvl;
    end
  end

  // R8
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(BBM_CYC));

  // R3
  hiz_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_hiz) |-> busy);

  // R3
  hiz_onset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !busy && lvl_sel != LVL_BAD) |=> (ch_hiz != '0) && busy && !sel_err);

  // R4
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ch_level) |-> $fell(busy));

  // R6
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !release_now) |=> $stable(ch_hiz) && $stable(sel_err));

  // R7
  illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !busy && lvl_sel == LVL_BAD) |=> (ch_hiz == '0) && sel_err && !busy);

endmodule

// File: tb/tb_mcp_out_sel.sv
module tb_mcp_out_sel;
  localparam int NCH = 16;
  localparam int BBM = 4;
  localparam int AW  = $clog2(NCH);

  logic clk = 0, rst_n = 0, strobe = 0;
  logic [1:0] grp_mode = 0, lvl_sel = 0;
  logic [AW-1:0] grp_addr = 0;
  logic [2*NCH-1:0] ch_level;
  logic [NCH-1:0] ch_hiz;
  logic busy, sel_err;

  int checks = 0, fails = 0;
  logic [2*NCH-1:0] exp_lvl;
  logic done = 0;

  always #2 clk = ~clk;

  mcp_out_sel #(.NCH(NCH), .BBM_CYC(BBM)) dut (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .grp_mode(grp_mode),
    .lvl_sel(lvl_sel), .grp_addr(grp_addr), .ch_level(ch_level),
    .ch_hiz(ch_hiz), .busy(busy), .sel_err(sel_err));

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [NCH-1:0] grp_mask(logic [1:0] m, int a);
    int size = (m == 2'b11) ? NCH : (1 << m);
    int base = (a / size) * size;
    logic [NCH-1:0] r = '0;
    for (int i = 0; i < NCH; i++)
      if (i >= base && i < base + size) r[i] = 1'b1;
    return r;
  endfunction

  function automatic logic [2*NCH-1:0] apply(logic [2*NCH-1:0] cur,
                                             logic [NCH-1:0] msk, logic [1:0] l);
    logic [2*NCH-1:0] r = cur;
    for (int i = 0; i < NCH; i++)
      if (msk[i]) r[2*i +: 2] = l;
    return r;
  endfunction

  task automatic do_op(logic [1:0] m, logic [1:0] l, int a, bit inject);
    logic [NCH-1:0] msk = grp_mask(m, a);
    @(negedge clk);
    grp_mode = m; lvl_sel = l; grp_addr = AW'(a); strobe = 1;
    @(negedge clk);
    strobe = 0;
    if (l == 2'b11) begin
      chk("R7 hiz", 64'(ch_hiz), 64'(0));
      chk("R7 err", 64'(sel_err), 64'(1));
      chk("R7 busy", 64'(busy), 64'(0));
      chk("R7 level", 64'(ch_level), 64'(exp_lvl));
      return;
    end
    chk("R3 R2 mask", 64'(ch_hiz), 64'(msk));
    chk("R8 busy", 64'(busy), 64'(1));
    chk("R7 err cleared", 64'(sel_err), 64'(0));
    chk("R4 R5 level held", 64'(ch_level), 64'(exp_lvl));
    for (int k = 1; k < BBM; k++) begin
      strobe = inject && (k == 2);
      if (strobe) begin
        grp_mode = 2'b11; lvl_sel = 2'b11; grp_addr = AW'(a + 5);
      end
      @(negedge clk);
      chk("R4 R6 hiz window", 64'(ch_hiz), 64'(msk));
      chk("R4 level window", 64'(ch_level), 64'(exp_lvl));
      chk("R6 err stable", 64'(sel_err), 64'(0));
    end
    strobe = 0;
    @(negedge clk);
    exp_lvl = apply(exp_lvl, msk, l);
    chk("R4 released", 64'(ch_hiz), 64'(0));
    chk("R8 idle", 64'(busy), 64'(0));
    chk("R4 R5 R6 level", 64'(ch_level), 64'(exp_lvl));
  endtask

  initial begin
    void'($urandom(32'd1234));
    exp_lvl = {NCH{2'b01}};
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 level", 64'(ch_level), 64'(exp_lvl));
    chk("R1 hiz", 64'(ch_hiz), 64'(0));
    chk("R1 busy", 64'(busy), 64'(0));
    chk("R1 err", 64'(sel_err), 64'(0));

    do_op(2'b00, 2'b00, 15, 0);
    do_op(2'b01, 2'b10, 7, 0);
    do_op(2'b10, 2'b00, 13, 1);
    do_op(2'b11, 2'b10, 3, 0);
    do_op(2'b00, 2'b11, 2, 0);
    do_op(2'b00, 2'b11, 9, 0);
    chk("R7 err sticky", 64'(sel_err), 64'(1));
    do_op(2'b01, 2'b01, 0, 1);

    // R9: strobe held high across and beyond the window
    @(negedge clk);
    grp_mode = 2'b00; lvl_sel = 2'b00; grp_addr = 4'd6; strobe = 1;
    repeat (BBM + 4) @(negedge clk);
    exp_lvl = apply(exp_lvl, grp_mask(2'b00, 6), 2'b00);
    chk("R9 no retrigger busy", 64'(busy), 64'(0));
    chk("R9 level", 64'(ch_level), 64'(exp_lvl));
    strobe = 0;

    for (int n = 0; n < 60; n++)
      do_op(2'($urandom), 2'($urandom), int'($urandom % NCH), bit'($urandom));
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule